// File: doc/BRIEF.md
# Lockable Real-Time Clock with Alarm

This block keeps time of day for software. A 45-bit tick counter advances once for every cycle in which the tick-enable input is high and counting is switched on. A separate seconds register advances whenever a one-second boundary passes. The boundary can come from the carry out of the low sub-second bits of the counter, which suits a 32.768 kHz tick. It can instead come from a divide-by-38400 prescaler, which suits a 38.4 kHz tick. An alarm register is compared against the seconds value as it advances. Both the alarm match and the per-second event set sticky status flags, and each flag drives a maskable interrupt line.

The counter, seconds and alarm values have no reset, so the power-on reset leaves them as they were and only software writes set them. The power-on reset clears the control bits and the flags, and it write-protects the control, count, seconds and alarm registers. Each protected register has a companion key register. Writing the key word to the key register opens its companion for writes, and writing any other value closes it again. Software uses a simple single-cycle write strobe with an address and a combinational read port.

Top module: `rtc_keylock`

## Requirements
- R1: While control bit 0 (run) is 1, each cycle with `tick` high adds one to the counter, which wraps from all ones to zero; while run is 0 the counter holds.
- R2: The power-on reset `por_n` does not alter the counter, seconds or alarm values; it clears control bits [3:0] and the flags at bits [9:8].
- R3: With control bit 3 at 0, the seconds register gains one on each advance that takes the low FRAC_W counter bits from all ones to zero.
- R4: With control bit 3 at 1, the seconds register gains one on every ALT_DIV-th advance; a write to the seconds register restarts this prescaler from zero.
- R5: When the seconds register advances to a value equal to the alarm register, the alarm flag (control bit 8) is set; `irq_alarm` is high while that flag and control bit 1 are both 1.
- R6: Each seconds event sets the second flag (control bit 9); `irq_sec` is high while that flag and control bit 2 are both 1.
- R7: The flags stay set until a write to address 0 with a 1 in the flag's bit position; this clear works whether or not the control register is protected, and a flag set in the same cycle stays set.
- R8: After power-on reset all four protected registers are locked, and a write to a locked register leaves it unchanged.
- R9: Writing 0x55CCAA33 to a key register (address 8 for control, 9 for count, 10 for seconds, 11 for alarm) unlocks only its companion; any other value written there locks it.
- R10: An accepted write to the count low word (address 1) or high bits (address 2) replaces that part, and the counter does not advance in that cycle.
- R11: An accepted write to the seconds register (address 3) takes effect in place of any seconds advance in that cycle, and no alarm match is checked in that cycle.
- R12: Reads are: address 0 gives {flags at [9:8], control at [3:0]}, 1 gives count[31:0], 2 gives count[44:32] zero-extended, 3 gives seconds, 4 gives alarm, and every other address gives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Time-base tick enable, one cycle per counted tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_alarm | output | 1 | Alarm interrupt, flag and enable both set |
| irq_sec | output | 1 | Per-second interrupt, flag and enable both set |

## Verification
The bench builds the block with FRAC_W = 4 and ALT_DIV = 6, so a seconds event falls every 16 or every 6 ticks. This lets many seconds, alarm matches and prescaler restarts occur in a short run. The counter keeps its full 45-bit width, and the wrap from all ones to zero is reached by loading values near the top through the write port. The small divisors also make it easy to line up a seconds event in the same cycle as a flag clear or a seconds write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int NUM_LOCKS = 4;

    localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h55CC_AA33;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 4'd0,
        A_CNT_LO   = 4'd1,
        A_CNT_HI   = 4'd2,
        A_SEC      = 4'd3,
        A_ALARM    = 4'd4,
        A_KEY_CTRL = 4'd8,
        A_KEY_CNT  = 4'd9,
        A_KEY_SEC  = 4'd10,
        A_KEY_ALM  = 4'd11
    } reg_addr_e;

    // Lock index order matches key address order (A_KEY_CTRL + index)
    localparam int L_CTRL = 0;
    localparam int L_CNT  = 1;
    localparam int L_SEC  = 2;
    localparam int L_ALM  = 3;

    localparam int FLG_ALM_BIT = 8;
    localparam int FLG_SEC_BIT = 9;

    typedef struct packed {
        logic alt_mode;
        logic sec_en;
        logic alm_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/rtc_lockbank.sv
module rtc_lockbank
    import rtc_pkg::*;
#(
    parameter int N = NUM_LOCKS
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [N-1:0]      key_wr,
    input  logic [DATA_W-1:0] key_data,
    output logic [N-1:0]      locked
);

    logic [N-1:0] lock_d, lock_q;
    logic         key_ok;

    assign key_ok = (key_data == UNLOCK_WORD);

    for (genvar i = 0; i < N; i++) begin : g_lock
        always_comb begin
            lock_d[i] = lock_q[i];
            if (key_wr[i]) begin
                lock_d[i] = !key_ok;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            lock_q <= '1;
        end else begin
            lock_q <= lock_d;
        end
    end

    assign locked = lock_q;

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
#(
    parameter int CNT_W = 45
) (
    input  logic              clk,
    input  logic              adv,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] cnt_lo,
    output logic [DATA_W-1:0] cnt_hi
);

    localparam int LO_W = (CNT_W > DATA_W) ? DATA_W : CNT_W;
    localparam int HI_W = (CNT_W > DATA_W) ? CNT_W - DATA_W : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // No reset: the time value survives every reset and is set by software only
    if (CNT_W > DATA_W) begin : g_split
        always_comb begin
            cnt_d = cnt_q;
            if (adv) begin
                cnt_d = cnt_q + 1'b1;
            end
            if (wr_lo) begin
                cnt_d[LO_W-1:0] = wdata[LO_W-1:0];
            end
            if (wr_hi) begin
                cnt_d[CNT_W-1:LO_W] = wdata[HI_W-1:0];
            end
        end
        assign cnt_lo = cnt_q[LO_W-1:0];
        assign cnt_hi = DATA_W'(cnt_q[CNT_W-1:LO_W]);
    end else begin : g_flat
        always_comb begin
            cnt_d = cnt_q;
            if (adv) begin
                cnt_d = cnt_q + 1'b1;
            end
            if (wr_lo) begin
                cnt_d = wdata[CNT_W-1:0];
            end
        end
        assign cnt_lo = DATA_W'(cnt_q);
        assign cnt_hi = '0;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int ALT_DIV = 38400
) (
    input  logic clk,
    input  logic adv,
    input  logic alt_mode,
    input  logic frac_full,
    input  logic clr,
    output logic sec_evt
);

    localparam int PRE_W = (ALT_DIV > 1) ? $clog2(ALT_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(ALT_DIV - 1);

    logic [PRE_W-1:0] pre_d, pre_q;
    logic             pre_wrap;

    assign pre_wrap = (pre_q == PRE_LAST);

    always_comb begin
        sec_evt = 1'b0;
        if (adv) begin
            sec_evt = alt_mode ? pre_wrap : frac_full;
        end
    end

    always_comb begin
        pre_d = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (adv && alt_mode) begin
            pre_d = pre_wrap ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        pre_q <= pre_d;
    end

endmodule

// File: rtl/rtc_keylock.sv
module rtc_keylock
    import rtc_pkg::*;
#(
    parameter int CNT_W   = 45,
    parameter int FRAC_W  = 15,
    parameter int ALT_DIV = 38400
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_alarm,
    output logic              irq_sec
);

    typedef struct packed {
        ctrl_t ctrl;
        logic  alm_flg;
        logic  sec_flg;
    } cfg_s;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] alarm;
    } time_s;

    cfg_s  cfg_d, cfg_q;
    time_s tm_d, tm_q;

    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] key_wr;
    logic [CNT_W-1:0]     cnt_q;
    logic [DATA_W-1:0]    cnt_lo, cnt_hi;

    logic hit_ctrl, wr_ctrl, wr_cnt_lo, wr_cnt_hi, wr_sec, wr_alarm;
    logic adv, sec_evt, alarm_hit;
    logic [DATA_W-1:0] sec_inc;

    // Write decode; a locked target drops the write
    always_comb begin
        hit_ctrl  = wr_en && (addr == A_CTRL);
        wr_ctrl   = hit_ctrl && !lock_q[L_CTRL];
        wr_cnt_lo = wr_en && (addr == A_CNT_LO) && !lock_q[L_CNT];
        wr_cnt_hi = wr_en && (addr == A_CNT_HI) && !lock_q[L_CNT];
        wr_sec    = wr_en && (addr == A_SEC)    && !lock_q[L_SEC];
        wr_alarm  = wr_en && (addr == A_ALARM)  && !lock_q[L_ALM];
    end

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_keydec
        assign key_wr[i] = wr_en && (addr == (A_KEY_CTRL + ADDR_W'(i)));
    end

    assign adv = cfg_q.ctrl.run && tick && !(wr_cnt_lo || wr_cnt_hi);

    rtc_lockbank #(
        .N (NUM_LOCKS)
    ) u_locks (
        .clk      (clk),
        .por_n    (por_n),
        .key_wr   (key_wr),
        .key_data (wdata),
        .locked   (lock_q)
    );

    rtc_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .adv    (adv),
        .wr_lo  (wr_cnt_lo),
        .wr_hi  (wr_cnt_hi),
        .wdata  (wdata),
        .cnt    (cnt_q),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi)
    );

    rtc_prescale #(
        .ALT_DIV (ALT_DIV)
    ) u_pre (
        .clk       (clk),
        .adv       (adv),
        .alt_mode  (cfg_q.ctrl.alt_mode),
        .frac_full (&cnt_q[FRAC_W-1:0]),
        .clr       (wr_sec),
        .sec_evt   (sec_evt)
    );

    assign sec_inc   = tm_q.sec + 1'b1;
    assign alarm_hit = sec_evt && !wr_sec && (sec_inc == tm_q.alarm);

    // Next-state computation for seconds, alarm, control and flags
    always_comb begin
        tm_d  = tm_q;
        cfg_d = cfg_q;

        if (wr_sec) begin
            tm_d.sec = wdata;
        end else if (sec_evt) begin
            tm_d.sec = sec_inc;
        end

        if (wr_alarm) begin
            tm_d.alarm = wdata;
        end

        if (wr_ctrl) begin
            cfg_d.ctrl = ctrl_t'(wdata[3:0]);
        end

        // Flag clear is not protected; a same-cycle set wins
        if (hit_ctrl && wdata[FLG_ALM_BIT]) begin
            cfg_d.alm_flg = 1'b0;
        end
        if (hit_ctrl && wdata[FLG_SEC_BIT]) begin
            cfg_d.sec_flg = 1'b0;
        end
        if (alarm_hit) begin
            cfg_d.alm_flg = 1'b1;
        end
        if (sec_evt) begin
            cfg_d.sec_flg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_ff @(posedge clk) begin
        tm_q <= tm_d;
    end

    // Read mux
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {{(DATA_W-10){1'b0}}, cfg_q.sec_flg, cfg_q.alm_flg,
                               4'b0000, cfg_q.ctrl};
            A_CNT_LO: rdata = cnt_lo;
            A_CNT_HI: rdata = cnt_hi;
            A_SEC:    rdata = tm_q.sec;
            A_ALARM:  rdata = tm_q.alarm;
            default:  rdata = '0;
        endcase
    end

    assign irq_alarm = cfg_q.alm_flg && cfg_q.ctrl.alm_en;
    assign irq_sec   = cfg_q.sec_flg && cfg_q.ctrl.sec_en;

endmodule

// File: rtl/rtc_keylock_chk.sv
module rtc_keylock_chk
    import rtc_pkg::*;
#(
    parameter int CNT_W = 45
) (
    input logic                 clk,
    input logic                 por_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [DATA_W-1:0]    wdata,
    input logic                 tick,
    input logic                 run,
    input logic [CNT_W-1:0]     cnt,
    input logic [DATA_W-1:0]    alarm,
    input logic [NUM_LOCKS-1:0] locks,
    input logic                 alm_flg
);

    logic cnt_touch;
    assign cnt_touch = wr_en && ((addr == A_CNT_LO) || (addr == A_CNT_HI));

    p_count_step_r1: assert property (@(posedge clk) disable iff (!por_n)
        (run && tick && !cnt_touch) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_count_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
        (!run && !cnt_touch) |=> $stable(cnt));

    p_alarm_locked_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && (addr == A_ALARM) && locks[L_ALM]) |=> $stable(alarm));

    p_key_unlock_r9: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && (addr == A_KEY_ALM) && (wdata == UNLOCK_WORD)) |=> !locks[L_ALM]);

    p_key_relock_r9: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && (addr == A_KEY_SEC) && (wdata != UNLOCK_WORD)) |=> locks[L_SEC]);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        (alm_flg && !(wr_en && (addr == A_CTRL) && wdata[FLG_ALM_BIT])) |=> alm_flg);

endmodule

bind rtc_keylock rtc_keylock_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tick    (tick),
    .run     (cfg_q.ctrl.run),
    .cnt     (cnt_q),
    .alarm   (tm_q.alarm),
    .locks   (lock_q),
    .alm_flg (cfg_q.alm_flg)
);

// File: tb/sim_rtc_keylock.sv
module sim_rtc_keylock;

    localparam int CNT_W   = 45;
    localparam int FRAC_W  = 4;
    localparam int ALT_DIV = 6;
    localparam logic [31:0] KEY = 32'h55CC_AA33;
    localparam longint unsigned CMASK = (64'd1 << CNT_W) - 1;
    localparam longint unsigned FMASK = (64'd1 << FRAC_W) - 1;
    localparam longint unsigned HMASK = (64'd1 << (CNT_W - 32)) - 1;

    logic        clk = 1'b0;
    logic        por_n;
    logic        tick;
    logic        wr_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_alarm;
    logic        irq_sec;

    always #10 clk = ~clk;

    rtc_keylock #(
        .CNT_W   (CNT_W),
        .FRAC_W  (FRAC_W),
        .ALT_DIV (ALT_DIV)
    ) u0 (
        .clk       (clk),
        .por_n     (por_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_alarm (irq_alarm),
        .irq_sec   (irq_sec)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Behavioural reference state
    longint unsigned m_cnt = 0;
    int unsigned     m_sec = 0, m_alm = 0;
    int              m_pre = 0;
    bit m_run, m_aen, m_sen, m_alt, m_af, m_sf;
    bit [3:0] m_lock;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_por();
        m_run = 0; m_aen = 0; m_sen = 0; m_alt = 0; m_af = 0; m_sf = 0;
        m_lock = 4'hF;
    endtask

    function automatic logic [31:0] mread(logic [3:0] a);
        case (a)
            4'd0:    return {22'd0, m_sf, m_af, 4'd0, m_alt, m_sen, m_aen, m_run};
            4'd1:    return m_cnt[31:0];
            4'd2:    return 32'(m_cnt >> 32);
            4'd3:    return m_sec;
            4'd4:    return m_alm;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_apply(bit w, logic [3:0] a, logic [31:0] d, bit t);
        bit cw, adv, evt, sw, af_set;
        cw  = w && (a == 4'd1 || a == 4'd2) && !m_lock[1];
        sw  = w && (a == 4'd3) && !m_lock[2];
        adv = m_run && t && !cw;
        evt = 0;
        if (adv) begin
            if (m_alt) evt = (m_pre == ALT_DIV - 1);
            else       evt = ((m_cnt & FMASK) == FMASK);
        end
        af_set = evt && !sw && ((m_sec + 32'd1) == m_alm);
        if (adv) m_cnt = (m_cnt + 1) & CMASK;
        if (cw && a == 4'd1) m_cnt = (m_cnt & 64'hFFFF_FFFF_0000_0000) | 64'(d);
        if (cw && a == 4'd2) m_cnt = (m_cnt & 64'h0000_0000_FFFF_FFFF) | ((64'(d) & HMASK) << 32);
        if (sw) m_pre = 0;
        else if (adv && m_alt) m_pre = (m_pre == ALT_DIV - 1) ? 0 : m_pre + 1;
        if (sw) m_sec = d;
        else if (evt) m_sec = m_sec + 32'd1;
        if (w && a == 4'd4 && !m_lock[3]) m_alm = d;
        if (w && a == 4'd0) begin
            if (d[8]) m_af = 0;
            if (d[9]) m_sf = 0;
        end
        if (af_set) m_af = 1;
        if (evt) m_sf = 1;
        if (w && a == 4'd0 && !m_lock[0]) {m_alt, m_sen, m_aen, m_run} = d[3:0];
        if (w && a >= 4'd8 && a <= 4'd11) m_lock[a - 4'd8] = (d != KEY);
    endtask

    // One clock: drive at negedge, model follows the edge, irq lines compared every clock
    task automatic step(bit w, logic [3:0] a, logic [31:0] d, bit t);
        wr_en = w; addr = a; wdata = d; tick = t;
        @(posedge clk);
        #1;
        model_apply(w, a, d, t);
        wr_en = 0; tick = 0;
        check("R5 irq_alarm", {31'd0, irq_alarm}, {31'd0, m_af & m_aen});
        check("R6 irq_sec",   {31'd0, irq_sec},   {31'd0, m_sf & m_sen});
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        step(1, a, d, 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(0, 4'd0, 32'd0, 1);
    endtask

    task automatic rd(string req, logic [3:0] a);
        addr = a; wr_en = 0;
        #1;
        check(req, rdata, mread(a));
    endtask

    task automatic do_por();
        por_n = 0;
        model_por();
        @(negedge clk);
        @(negedge clk);
        por_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        por_n = 0; tick = 0; wr_en = 0; addr = 0; wdata = 0;
        model_por();
        repeat (3) @(negedge clk);
        por_n = 1;

        // R2 R12: reset state of control and flags
        rd("R2 ctrl after reset", 4'd0);
        check("R2 ctrl literal", rdata, 32'd0);

        // R8 R9: locked write dropped, key opens, wrong key closes
        wr(4'd11, KEY);
        wr(4'd4, 32'h0000_00A5);
        wr(4'd11, 32'h1234_5678);
        wr(4'd4, 32'h0000_0077);
        rd("R8 alarm write while locked", 4'd4);
        check("R9 alarm literal", rdata, 32'h0000_00A5);

        // Open all four for setup
        wr(4'd8, KEY); wr(4'd9, KEY); wr(4'd10, KEY); wr(4'd11, KEY);
        wr(4'd2, 32'h0000_1FFF);
        wr(4'd1, 32'hFFFF_FFFD);
        wr(4'd3, 32'd10);
        wr(4'd4, 32'd12);
        rd("R12 count high read", 4'd2);
        check("R12 count high literal", rdata, 32'h0000_1FFF);
        wr(4'd0, 32'h0000_0007);

        // R1 R3: three ticks wrap the counter and cross a second boundary
        ticks(3);
        rd("R1 count wrap low", 4'd1);
        check("R1 wrap literal", rdata, 32'd0);
        rd("R1 count wrap high", 4'd2);
        rd("R3 seconds after carry", 4'd3);
        check("R3 seconds literal", rdata, 32'd11);
        rd("R6 second flag", 4'd0);

        // R1: no tick -> hold; run off -> hold
        step(0, 4'd0, 32'd0, 0);
        rd("R1 hold without tick", 4'd1);
        wr(4'd0, 32'h0000_0006);
        ticks(5);
        rd("R1 hold with run off", 4'd1);
        wr(4'd0, 32'h0000_0007);

        // R5: sixteen ticks reach seconds 12 == alarm
        ticks(16);
        rd("R5 seconds at alarm", 4'd3);
        rd("R5 alarm flag", 4'd0);
        check("R5 alarm flag literal", rdata & 32'h100, 32'h100);

        // R7: write-one clear; clear works while ctrl locked; R8 ctrl bits kept
        wr(4'd0, 32'h0000_0207);
        rd("R7 second flag cleared", 4'd0);
        wr(4'd8, 32'h0);
        wr(4'd0, 32'h0000_0100);
        rd("R7 R8 clear while locked", 4'd0);
        check("R8 run kept literal", rdata & 32'h10F, 32'h007);

        // R7: set wins over clear in the same cycle
        wr(4'd1, 32'h0000_000F);
        step(1, 4'd0, 32'h0000_0200, 1);
        rd("R7 set wins", 4'd0);
        check("R7 set wins literal", rdata & 32'h200, 32'h200);

        // R4: alternate divider
        wr(4'd8, KEY);
        wr(4'd0, 32'h0000_000F);
        wr(4'd3, 32'd100);
        ticks(5);
        rd("R4 before sixth tick", 4'd3);
        ticks(1);
        rd("R4 after sixth tick", 4'd3);
        check("R4 literal", rdata, 32'd101);
        ticks(12);
        rd("R4 two more seconds", 4'd3);

        // R11: seconds write collides with an event
        ticks(5);
        step(1, 4'd3, 32'd200, 1);
        rd("R11 write wins over event", 4'd3);
        check("R11 literal", rdata, 32'd200);
        wr(4'd4, 32'd201);
        ticks(5);
        rd("R11 prescaler restarted", 4'd3);
        ticks(1);
        rd("R5 alarm in alternate mode", 4'd0);

        // R10: count write suppresses advance
        step(1, 4'd1, 32'h0000_0050, 1);
        rd("R10 write without advance", 4'd1);
        check("R10 literal", rdata, 32'h0000_0050);

        // R2: power-on reset keeps time values, relocks, clears control
        do_por();
        rd("R2 count low kept", 4'd1);
        rd("R2 count high kept", 4'd2);
        rd("R2 seconds kept", 4'd3);
        rd("R2 alarm kept", 4'd4);
        rd("R2 ctrl cleared", 4'd0);
        wr(4'd4, 32'd5);
        rd("R8 alarm locked after reset", 4'd4);

        // R9: key opens only its companion
        wr(4'd10, KEY);
        wr(4'd3, 32'd7);
        wr(4'd4, 32'd9);
        rd("R9 seconds opened", 4'd3);
        check("R9 seconds literal", rdata, 32'd7);
        rd("R9 alarm still locked", 4'd4);
        rd("R12 key address reads zero", 4'd10);
        check("R12 key read literal", rdata, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule